// File: doc/BRIEF.md
# SPI Wiper Register Command Decoder

This block is a serial slave that holds a small bank of 9-bit wiper settings and updates them from commands sent over a four-wire SPI link in mode 0. A transfer is framed by an active-low chip select. Each command begins with one byte that carries a 4-bit register address, a 2-bit opcode and two upper data bits. Write and read commands are followed by a second byte, and the low bit of the first byte joins that byte to form a 9-bit value. Increment and decrement are one byte long and step the addressed wiper by one count, stopping at its ends.

The serial pins are brought into the system clock domain through synchronizer flops. All decoding, wiper updates and SDO generation then run synchronously. While the first byte is arriving, the block checks the address and opcode together and reports the result on SDO. If the pair is invalid, the block locks out the rest of the frame until chip select is released. A command that is cut short by chip select going high has no effect. Several complete commands may be chained in one frame. The wiper values are also available in parallel on an output bus, which feeds the analogue network.

Top module: `spi_pot_decoder`

## Requirements
- R1: After synchronous reset every wiper holds 0x080, and spi_sdo is high.
- R2: A command byte is received MSB first in the order A3 A2 A1 A0 P1 P0 X D8. The opcode P1:P0 is decoded as 00 write, 01 increment, 10 decrement and 11 read. Addresses 0 and 1 select wipers 0 and 1 and are valid with every opcode. Addresses 2 to 15 are invalid.
- R3: A write takes 16 SCK clocks. After the sixteenth rising edge the addressed wiper becomes {D8, data byte}, with the data byte sent MSB first.
- R4: An increment leaves a wiper unchanged if its value is 0x100 or above, and otherwise adds one. A decrement leaves a wiper at 0x000 unchanged, and otherwise subtracts one. Both act after the eighth rising edge.
- R5: During a read, SDO carries the addressed wiper MSB first. Bit 8 is in the D8 slot of the command byte and bits 7 to 0 are in the data byte. The wiper is not changed.
- R6: For a valid pair, SDO is high in every slot of the command byte except the D8 slot of a read. In particular it is high in the seventh slot (the X position), which reports the status. SDO is also high in every data-byte slot of a write.
- R7: For an invalid pair, SDO is low from the seventh slot onward, and every later command in the same frame is ignored. Normal operation resumes in the next frame.
- R8: A command that is interrupted by chip select rising before its last clock does not change any wiper.
- R9: SCK and SDI activity while chip select is high changes no wiper, and SDO stays high.
- R10: Commands chained within one frame each take effect in order. A read that follows a write in the same frame returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, mode 0 |
| spi_cs_n | input | 1 | Active-low chip select framing a transfer |
| spi_sdi | input | 1 | Serial data from the master, sampled on SCK rising edges |
| spi_sdo | output | 1 | Serial data to the master, updated after SCK falling edges |
| wiper_o | output | NUM_WIPERS*9 | Wiper values, wiper i at bits [9*i+8:9*i] |

## Verification
The hardest state to reach from the ports is the error lockout in the middle of a frame. Here the status has already been driven low, and a perfectly valid write follows in the same frame and must be dropped. The bench sweeps all 64 address and opcode pairs. After each invalid pair it appends a complete write to wiper 0, then checks that both the SDO bytes are zero and the wiper value is unchanged. Truncated frames are made by raising chip select after 7 or 12 clocks. Saturation is reached by chaining several steps in one frame, starting from values written just inside each limit.

// File: rtl/spi_pot_pkg.sv
// Package: shared opcode and frame-phase types for the wiper command decoder.
// Assumes an 8-bit command byte: 4 address bits, 2 opcode bits, 2 data bits.
package spi_pot_pkg;

    localparam int BYTE_W   = 8;
    localparam int ADDR_W   = 4;
    localparam int OP_W     = 2;
    localparam int WIPER_W  = 9;
    localparam int BITCNT_W = $clog2(BYTE_W);

    typedef enum logic [OP_W-1:0] {
        OP_WRITE = 2'b00,
        OP_INC   = 2'b01,
        OP_DEC   = 2'b10,
        OP_READ  = 2'b11
    } pot_op_e;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } frame_phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
// Module: spi_pin_sync
// Brings SCK, SDI and CS_n into the clk domain through a flop chain and
// produces one-cycle SCK edge pulses and a CS falling-edge pulse.
// Assumes each SCK phase lasts several clk periods (at least STAGES + 2).
module spi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic sdi,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi_s,
    output logic cs_n_s,
    output logic cs_fall
);

    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] sdi_q;
    logic [STAGES-1:0] cs_q;
    logic              sck_prev;
    logic              cs_prev;

    // Purpose: shift each pin through its synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q    <= '0;
            sdi_q    <= '0;
            cs_q     <= '1;
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_q    <= {sck_q[STAGES-2:0], sck};
            sdi_q    <= {sdi_q[STAGES-2:0], sdi};
            cs_q     <= {cs_q[STAGES-2:0], cs_n};
            sck_prev <= sck_q[STAGES-1];
            cs_prev  <= cs_q[STAGES-1];
        end
    end

    // Purpose: derive edge pulses from the last synchronizer stage.
    always_comb begin
        sck_rise = sck_q[STAGES-1] & ~sck_prev;
        sck_fall = ~sck_q[STAGES-1] & sck_prev;
        sdi_s    = sdi_q[STAGES-1];
        cs_n_s   = cs_q[STAGES-1];
        cs_fall  = cs_prev & ~cs_q[STAGES-1];
    end

endmodule

// File: rtl/pot_cmd_framer.sv
// Module: pot_cmd_framer
// Frames commands within a CS frame: counts bits, captures address and
// opcode after the sixth bit, checks the pair, issues one-cycle update
// pulses at byte ends and chooses the SDO bit on each SCK falling edge.
// Assumes synchronized inputs and one SCK edge pulse at most per cycle.
module pot_cmd_framer
    import spi_pot_pkg::*;
#(
    parameter int NUM_WIPERS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_rise,
    input  logic               sck_fall,
    input  logic               sdi_s,
    input  logic               cs_n_s,
    input  logic               cs_fall,
    input  logic [WIPER_W-1:0] sel_value,
    output logic [ADDR_W-1:0]  tgt_addr,
    output logic               wr_pulse,
    output logic               inc_pulse,
    output logic               dec_pulse,
    output logic [WIPER_W-1:0] wr_data,
    output logic               sdo,
    output logic               frame_active,
    output logic               lock_err
);

    localparam logic [ADDR_W:0]   NUM_A    = (ADDR_W+1)'(NUM_WIPERS);
    localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(BYTE_W - 1);
    localparam logic [BITCNT_W-1:0] PAIR_BIT = BITCNT_W'(ADDR_W + OP_W - 1);

    logic [BYTE_W-2:0]   shreg;
    logic [BITCNT_W-1:0] bitcnt;
    frame_phase_e        phase;
    pot_op_e             cmd_op;
    logic                cmd_d8;
    logic [BYTE_W-1:0]   full_byte;
    logic [ADDR_W-1:0]   early_addr;
    pot_op_e             early_op;
    logic                slot_bit;

    // Purpose: view of the byte in flight including the bit now sampled.
    always_comb begin
        full_byte  = {shreg, sdi_s};
        early_addr = shreg[ADDR_W:1];
        early_op   = pot_op_e'({shreg[0], sdi_s});
    end

    // Purpose: SDO value for the slot that follows the current bit count.
    always_comb begin
        if (phase == PH_CMD) begin
            slot_bit = (bitcnt == LAST_BIT && cmd_op == OP_READ) ?
                       sel_value[WIPER_W-1] : 1'b1;
        end else begin
            slot_bit = (cmd_op == OP_READ) ? sel_value[~bitcnt] : 1'b1;
        end
    end

    // Purpose: frame state, command capture, update pulses and SDO register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg        <= '0;
            bitcnt       <= '0;
            phase        <= PH_CMD;
            cmd_op       <= OP_WRITE;
            cmd_d8       <= 1'b0;
            tgt_addr     <= '0;
            wr_pulse     <= 1'b0;
            inc_pulse    <= 1'b0;
            dec_pulse    <= 1'b0;
            wr_data      <= '0;
            sdo          <= 1'b1;
            frame_active <= 1'b0;
            lock_err     <= 1'b0;
        end else begin
            wr_pulse  <= 1'b0;
            inc_pulse <= 1'b0;
            dec_pulse <= 1'b0;
            if (cs_n_s) begin
                frame_active <= 1'b0;
                lock_err     <= 1'b0;
                bitcnt       <= '0;
                phase        <= PH_CMD;
                sdo          <= 1'b1;
            end else if (cs_fall) begin
                frame_active <= 1'b1;
                lock_err     <= 1'b0;
                bitcnt       <= '0;
                phase        <= PH_CMD;
                sdo          <= 1'b1;
            end else if (frame_active) begin
                if (sck_rise && !lock_err) begin
                    shreg  <= full_byte[BYTE_W-2:0];
                    bitcnt <= bitcnt + 1'b1;
                    if (phase == PH_CMD && bitcnt == PAIR_BIT) begin
                        tgt_addr <= early_addr;
                        cmd_op   <= early_op;
                        if ({1'b0, early_addr} >= NUM_A) begin
                            lock_err <= 1'b1;
                        end
                    end
                    if (bitcnt == LAST_BIT) begin
                        if (phase == PH_CMD) begin
                            cmd_d8 <= sdi_s;
                            case (cmd_op)
                                OP_INC:  inc_pulse <= 1'b1;
                                OP_DEC:  dec_pulse <= 1'b1;
                                default: phase     <= PH_DATA;
                            endcase
                        end else begin
                            phase <= PH_CMD;
                            if (cmd_op == OP_WRITE) begin
                                wr_pulse <= 1'b1;
                                wr_data  <= {cmd_d8, full_byte};
                            end
                        end
                    end
                end
                if (sck_fall) begin
                    sdo <= lock_err ? 1'b0 : slot_bit;
                end
            end
        end
    end

endmodule

// File: rtl/pot_wiper_bank.sv
// Module: pot_wiper_bank
// Holds the wiper registers, applies write, saturating increment and
// decrement to the addressed wiper, and returns the addressed wiper value.
// Assumes at most one of the update pulses is high in any cycle.
module pot_wiper_bank
    import spi_pot_pkg::*;
#(
    parameter int NUM_WIPERS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             tgt_addr,
    input  logic                          wr_pulse,
    input  logic                          inc_pulse,
    input  logic                          dec_pulse,
    input  logic [WIPER_W-1:0]            wr_data,
    output logic [WIPER_W-1:0]            sel_value,
    output logic [NUM_WIPERS*WIPER_W-1:0] wipers_flat
);

    localparam int                 SEL_W     = (NUM_WIPERS > 1) ? $clog2(NUM_WIPERS) : 1;
    localparam logic [WIPER_W-1:0] FULL_VAL  = WIPER_W'(1) << (WIPER_W - 1);
    localparam logic [WIPER_W-1:0] MID_VAL   = WIPER_W'(1) << (WIPER_W - 2);
    localparam logic [ADDR_W:0]    NUM_A     = (ADDR_W+1)'(NUM_WIPERS);

    logic [WIPER_W-1:0] wv [NUM_WIPERS];

    for (genvar gi = 0; gi < NUM_WIPERS; gi++) begin : g_wiper
        logic hit;
        assign hit = (tgt_addr == ADDR_W'(gi));

        // Purpose: update one wiper from the pulse aimed at its address.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wv[gi] <= MID_VAL;
            end else if (hit && wr_pulse) begin
                wv[gi] <= wr_data;
            end else if (hit && inc_pulse && wv[gi] < FULL_VAL) begin
                wv[gi] <= wv[gi] + 1'b1;
            end else if (hit && dec_pulse && wv[gi] != '0) begin
                wv[gi] <= wv[gi] - 1'b1;
            end
        end

        assign wipers_flat[gi*WIPER_W +: WIPER_W] = wv[gi];
    end

    // Purpose: readback mux for the addressed wiper, zero when out of range.
    always_comb begin
        if ({1'b0, tgt_addr} < NUM_A) begin
            sel_value = wv[tgt_addr[SEL_W-1:0]];
        end else begin
            sel_value = '0;
        end
    end

endmodule

// File: rtl/spi_pot_decoder.sv
// Module: spi_pot_decoder (top)
// SPI mode 0 slave decoding wiper commands: pin synchronizer, command
// framer and wiper bank. Assumes clk is several times faster than SCK.
module spi_pot_decoder #(
    parameter int NUM_WIPERS  = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck,
    input  logic                    spi_cs_n,
    input  logic                    spi_sdi,
    output logic                    spi_sdo,
    output logic [NUM_WIPERS*9-1:0] wiper_o
);

    import spi_pot_pkg::*;

    logic               sck_rise;
    logic               sck_fall;
    logic               sdi_s;
    logic               cs_n_s;
    logic               cs_fall;
    logic [ADDR_W-1:0]  tgt_addr;
    logic               wr_pulse;
    logic               inc_pulse;
    logic               dec_pulse;
    logic [WIPER_W-1:0] wr_data;
    logic [WIPER_W-1:0] sel_value;
    logic               frame_active;
    logic               lock_err;

    spi_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (spi_sck),
        .sdi      (spi_sdi),
        .cs_n     (spi_cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi_s    (sdi_s),
        .cs_n_s   (cs_n_s),
        .cs_fall  (cs_fall)
    );

    pot_cmd_framer #(
        .NUM_WIPERS (NUM_WIPERS)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .sck_rise     (sck_rise),
        .sck_fall     (sck_fall),
        .sdi_s        (sdi_s),
        .cs_n_s       (cs_n_s),
        .cs_fall      (cs_fall),
        .sel_value    (sel_value),
        .tgt_addr     (tgt_addr),
        .wr_pulse     (wr_pulse),
        .inc_pulse    (inc_pulse),
        .dec_pulse    (dec_pulse),
        .wr_data      (wr_data),
        .sdo          (spi_sdo),
        .frame_active (frame_active),
        .lock_err     (lock_err)
    );

    pot_wiper_bank #(
        .NUM_WIPERS (NUM_WIPERS)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .tgt_addr    (tgt_addr),
        .wr_pulse    (wr_pulse),
        .inc_pulse   (inc_pulse),
        .dec_pulse   (dec_pulse),
        .wr_data     (wr_data),
        .sel_value   (sel_value),
        .wipers_flat (wiper_o)
    );

endmodule

// File: rtl/pot_decoder_checker.sv
// Module: pot_decoder_checker
// Temporal checks on the decoder, attached to the top by bind.
// Assumes the update pulses and selected value come from separate blocks.
module pot_decoder_checker #(
    parameter int WIPER_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n_s,
    input logic               sck_fall,
    input logic               frame_active,
    input logic               lock_err,
    input logic               spi_sdo,
    input logic               wr_pulse,
    input logic               inc_pulse,
    input logic               dec_pulse,
    input logic [WIPER_W-1:0] sel_value
);

    localparam logic [WIPER_W-1:0] FULL_VAL = WIPER_W'(1) << (WIPER_W - 1);

    // R4: increment below full scale adds exactly one
    a_r4_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse && sel_value < FULL_VAL |=> sel_value == $past(sel_value) + 1'b1);

    // R4: increment at or above full scale holds the wiper
    a_r4_inc_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        inc_pulse && sel_value >= FULL_VAL |=> $stable(sel_value));

    // R4: decrement at zero holds the wiper
    a_r4_dec_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        dec_pulse && sel_value == '0 |=> sel_value == '0);

    // R7: locked frame drives SDO low after the next falling edge
    a_r7_lock_sdo_low: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err && sck_fall && !cs_n_s |=> !spi_sdo);

    // R7: no update is issued while locked
    a_r7_lock_no_update: assert property (@(posedge clk) disable iff (!rst_n)
        lock_err |-> !(wr_pulse || inc_pulse || dec_pulse));

    // R8: updates only inside an open frame
    a_r8_update_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse || inc_pulse || dec_pulse) |-> frame_active);

    // R9: chip select high closes the frame and parks SDO high
    a_r9_idle_sdo_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> spi_sdo && !frame_active);

    // R2: at most one update kind per cycle
    a_r2_single_update: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pulse, inc_pulse, dec_pulse}));

endmodule

bind spi_pot_decoder pot_decoder_checker #(
    .WIPER_W (9)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n_s       (cs_n_s),
    .sck_fall     (sck_fall),
    .frame_active (frame_active),
    .lock_err     (lock_err),
    .spi_sdo      (spi_sdo),
    .wr_pulse     (wr_pulse),
    .inc_pulse    (inc_pulse),
    .dec_pulse    (dec_pulse),
    .sel_value    (sel_value)
);

// File: tb/spi_pot_decoder_tb.sv
// Bench for spi_pot_decoder: sweeps every address/opcode pair, boundary
// write values, chained saturation steps, truncated frames and idle-CS
// traffic, against a wiper model kept in the bench.
module spi_pot_decoder_tb;

    localparam int NW = 2;
    localparam int H  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sck = 1'b0;
    logic          cs_n = 1'b1;
    logic          sdi = 1'b0;
    logic          sdo;
    logic [NW*9-1:0] wiper_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [8:0] model [NW];

    always #2.5 clk = ~clk;

    spi_pot_decoder #(.NUM_WIPERS(NW)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (sck),
        .spi_cs_n (cs_n),
        .spi_sdi  (sdi),
        .spi_sdo  (sdo),
        .wiper_o  (wiper_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(2*H);
    endtask

    task automatic frame_end();
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2*H);
    endtask

    task automatic xfer_bit(input logic b, output logic so);
        @(negedge clk);
        sdi = b;
        wait_clk(H);
        so = sdo;
        sck = 1'b1;
        wait_clk(H);
        sck = 1'b0;
    endtask

    task automatic xfer_bits(input logic [7:0] b, input int n, output logic [7:0] got);
        got = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            logic so;
            xfer_bit(b[i], so);
            got[i] = so;
        end
    endtask

    function automatic logic [7:0] cmd_byte(input logic [3:0] a, input logic [1:0] op,
                                            input logic d8);
        return {a, op, 1'b0, d8};
    endfunction

    task automatic check_wipers(input string req);
        for (int i = 0; i < NW; i++) begin
            check(wiper_o[i*9 +: 9] == model[i], req, $sformatf("wiper%0d", i),
                  int'(wiper_o[i*9 +: 9]), int'(model[i]));
        end
    endtask

    function automatic logic [8:0] step(input logic [8:0] v, input logic [1:0] op);
        if (op == 2'b01) return (v >= 9'h100) ? v : v + 9'd1;
        if (op == 2'b10) return (v == 9'h000) ? v : v - 9'd1;
        return v;
    endfunction

    function automatic logic [8:0] bval(input int i);
        case (i)
            0: return 9'h000;
            1: return 9'h001;
            2: return 9'h07F;
            3: return 9'h0FF;
            4: return 9'h100;
            5: return 9'h101;
            default: return 9'h1FF;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] g1, g2, g3;
        for (int i = 0; i < NW; i++) model[i] = 9'h080;
        wait_clk(10);
        rst_n = 1'b1;
        wait_clk(4);
        // R1: reset values
        check_wipers("R1");
        check(sdo == 1'b1, "R1", "sdo idle", int'(sdo), 1);

        // R2 R6 R7 R3 R4 R5: full address x opcode sweep
        for (int a = 0; a < 16; a++) begin
            for (int op = 0; op < 4; op++) begin
                logic [8:0] d;
                bit valid;
                d = 9'((a * 37 + op * 91 + 5) % 512);
                valid = (a < NW);
                frame_begin();
                xfer_bits(cmd_byte(4'(a), 2'(op), d[8]), 8, g1);
                if (!valid) begin
                    check(g1 == 8'hFC, "R7", $sformatf("status byte a=%0d op=%0d", a, op),
                          int'(g1), 'hFC);
                    xfer_bits(cmd_byte(4'd0, 2'b00, 1'b1), 8, g2);
                    xfer_bits(8'h55, 8, g3);
                    check({g2, g3} == 16'h0000, "R7", "locked sdo",
                          int'({g2, g3}), 0);
                end else if (op == 0 || op == 3) begin
                    logic [7:0] e1;
                    logic [7:0] e2;
                    e1 = (op == 3) ? {7'h7F, model[a][8]} : 8'hFF;
                    e2 = (op == 3) ? model[a][7:0] : 8'hFF;
                    check(g1 == e1, "R6", $sformatf("cmd sdo a=%0d op=%0d", a, op),
                          int'(g1), int'(e1));
                    xfer_bits(d[7:0], 8, g2);
                    check(g2 == e2, (op == 3) ? "R5" : "R6", "data sdo",
                          int'(g2), int'(e2));
                    if (op == 0) model[a] = d;
                end else begin
                    check(g1 == 8'hFF, "R6", $sformatf("cmd sdo a=%0d op=%0d", a, op),
                          int'(g1), 'hFF);
                    model[a] = step(model[a], 2'(op));
                end
                frame_end();
                check_wipers(valid ? "R2" : "R7");
            end
        end

        // R3 R5 R10: boundary writes chained with a read in one frame
        for (int i = 0; i < 7; i++) begin
            logic [8:0] v;
            v = bval(i);
            frame_begin();
            xfer_bits(cmd_byte(4'd1, 2'b00, v[8]), 8, g1);
            xfer_bits(v[7:0], 8, g1);
            xfer_bits(cmd_byte(4'd1, 2'b11, 1'b0), 8, g2);
            xfer_bits(8'h00, 8, g3);
            frame_end();
            model[1] = v;
            check({g2[0], g3} == v, "R10", "read after write", int'({g2[0], g3}), int'(v));
            check_wipers("R3");
        end

        // R4: chained increments saturate at 0x100
        frame_begin();
        xfer_bits(cmd_byte(4'd0, 2'b00, 1'b0), 8, g1);
        xfer_bits(8'hFE, 8, g1);
        for (int k = 0; k < 4; k++) xfer_bits(cmd_byte(4'd0, 2'b01, 1'b0), 8, g1);
        frame_end();
        model[0] = 9'h100;
        check_wipers("R4");

        // R4: increment above full scale holds
        frame_begin();
        xfer_bits(cmd_byte(4'd0, 2'b00, 1'b1), 8, g1);
        xfer_bits(8'hFF, 8, g1);
        xfer_bits(cmd_byte(4'd0, 2'b01, 1'b0), 8, g1);
        frame_end();
        model[0] = 9'h1FF;
        check_wipers("R4");

        // R4: chained decrements stop at zero
        frame_begin();
        xfer_bits(cmd_byte(4'd1, 2'b00, 1'b0), 8, g1);
        xfer_bits(8'h02, 8, g1);
        for (int k = 0; k < 4; k++) xfer_bits(cmd_byte(4'd1, 2'b10, 1'b0), 8, g1);
        frame_end();
        model[1] = 9'h000;
        check_wipers("R4");

        // R8: write cut after 12 clocks
        frame_begin();
        xfer_bits(cmd_byte(4'd0, 2'b00, 1'b0), 8, g1);
        xfer_bits(8'h33, 4, g1);
        frame_end();
        check_wipers("R8");

        // R8: increment cut after 7 clocks
        frame_begin();
        xfer_bits(cmd_byte(4'd1, 2'b01, 1'b0), 7, g1);
        frame_end();
        check_wipers("R8");

        // R9: traffic with chip select high
        xfer_bits(cmd_byte(4'd1, 2'b01, 1'b0), 8, g1);
        xfer_bits(cmd_byte(4'd0, 2'b00, 1'b0), 8, g2);
        xfer_bits(8'h11, 8, g3);
        check({g1, g2, g3} == 24'hFFFFFF, "R9", "sdo while idle",
              int'({g1, g2, g3}), 'hFFFFFF);
        wait_clk(2*H);
        check_wipers("R9");

        // R7: recovery in the frame after a lockout
        frame_begin();
        xfer_bits(cmd_byte(4'd9, 2'b01, 1'b0), 8, g1);
        frame_end();
        frame_begin();
        xfer_bits(cmd_byte(4'd1, 2'b01, 1'b0), 8, g1);
        frame_end();
        model[1] = 9'h001;
        check(g1 == 8'hFF, "R7", "status after recovery", int'(g1), 'hFF);
        check_wipers("R7");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule